// File: doc/BRIEF.md
# Pipeline Bypass and Interlock Control

This block steers operand forwarding and decides stalls for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle the decode stage presents its two source register numbers and a short description of how it uses them. The block compares them against the destination registers of the instructions ahead of it, which it tracks itself in three small stage records. It then produces mux selects for three places: the upper ALU operand in execute, the two inputs of the branch comparator that sits in decode, and the store-data path. The ALU does not evaluate branch conditions; it only forms the target address.

When no forwarding path can supply a needed value in time, the block raises a stall. The stall holds fetch and decode and puts an empty slot into execute. The stage records also carry an occupancy bit and an exception code down the pipe. An exception code already present is never overwritten by one found later. The datapath muxes, register file and memories sit outside the block. The register file writes early in a cycle and reads late, so a value in writeback can be read directly and needs no forwarding.

Top module: `bp_pipe_ctrl`

## Requirements
- R1: While rst_n is low, the ex/me/wb occupancy bits, the exception output and all registered selects are cleared at each clock edge.
- R2: The upper ALU operand select, registered into execute, is 1 (memory-stage result) if the execute-stage instruction writes rs, else 2 (writeback value) if the memory-stage instruction writes rs, else 0 (register file). The younger producer wins.
- R3: Register 0 never matches any producer. A stage that is unoccupied or does not write a register never matches either.
- R4: A load in execute that writes the rs used by the ALU in decode causes exactly one stall. After that the consumer is issued with upper select 2.
- R5: The lower ALU operand has no forwarding path. A decode instruction reading rt for the ALU stalls while execute or memory holds a producer of rt.
- R6: For a branch in decode, each comparator select (a: rs, b: rt) is 1 (memory-stage ALU result) when the memory stage holds a non-load producer of that register and execute does not. A producer in execute, or a load producer in memory, stalls the branch.
- R7: A store never stalls for its data register rt. ex_st_sel is 1 one cycle later when the memory stage held the producer. me_st_sel is 1 two cycles later when execute held it; execute has priority.
- R8: On a stall, the next cycle shows execute unoccupied with all its selects 0.
- R9: Occupancy moves one stage per cycle: ex to me to wb.
- R10: A nonzero exception code carried by an instruction keeps priority over a code newly detected in execute or memory. A zero code is replaced by the new one as the instruction moves on.
- R11: An unoccupied decode stage never stalls and drives comparator selects 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_occ | input | 1 | Decode stage holds an instruction |
| id_rs | input | REG_W | First source register number |
| id_rt | input | REG_W | Second source register number |
| id_dst | input | REG_W | Destination register number |
| id_wr | input | 1 | Instruction writes id_dst |
| id_load | input | 1 | Instruction is a load |
| id_use_a | input | 1 | rs feeds the upper ALU operand |
| id_use_b | input | 1 | rt feeds the lower ALU operand |
| id_branch | input | 1 | Conditional branch comparing rs and rt |
| id_store | input | 1 | Store whose data register is rt |
| id_exc | input | EXC_W | Exception code found up to decode (0 = none) |
| ex_exc_new | input | EXC_W | Exception code detected in execute |
| me_exc_new | input | EXC_W | Exception code detected in memory |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| id_cmp_a_sel | output | 1 | Comparator rs input: 0 register file, 1 memory-stage result |
| id_cmp_b_sel | output | 1 | Comparator rt input: 0 register file, 1 memory-stage result |
| ex_alu_a_sel | output | 2 | Upper ALU operand: 0 register, 1 memory result, 2 writeback value |
| ex_st_sel | output | 1 | Store data latched in execute: 0 carried, 1 writeback value |
| me_st_sel | output | 1 | Store data at memory input: 0 carried, 1 writeback value |
| ex_occ | output | 1 | Execute occupancy |
| me_occ | output | 1 | Memory occupancy |
| wb_occ | output | 1 | Writeback occupancy |
| wb_exc | output | EXC_W | Exception code reaching writeback |

## Verification
The bench builds the block with REG_W=3 and EXC_W=3. With only eight register numbers, random instruction streams hit the same register in two or three stages at once. That brings youngest-producer priority, load-use stalls and double branch stalls up often. The small exception width keeps colliding codes frequent, which tests keep-the-older priority. Directed sequences cover register 0, idle decode and each forwarding path separately.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int ASEL_W = 2;
    localparam logic [ASEL_W-1:0] ASEL_REG = 2'd0;
    localparam logic [ASEL_W-1:0] ASEL_MEM = 2'd1;
    localparam logic [ASEL_W-1:0] ASEL_WB  = 2'd2;
    localparam int NUM_SRC = 2;   // index 0 = rs, 1 = rt
endpackage

// File: rtl/bp_src_match.sv
module bp_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             ex_hit_en,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             me_hit_en,
    input  logic [REG_W-1:0] me_dst,
    output logic             hit_ex,
    output logic             hit_me
);
    logic src_nz;

    always_comb begin
        src_nz = (src != '0);
        hit_ex = src_nz && ex_hit_en && (ex_dst == src);
        hit_me = src_nz && me_hit_en && (me_dst == src);
    end
endmodule

// File: rtl/bp_hazard_decide.sv
module bp_hazard_decide
    import bp_pkg::*;
(
    input  logic                  id_occ,
    input  logic                  use_a,
    input  logic                  use_b,
    input  logic                  branch,
    input  logic                  store,
    input  logic [NUM_SRC-1:0]    hit_ex,
    input  logic [NUM_SRC-1:0]    hit_me,
    input  logic                  ex_ld,
    input  logic                  me_ld,
    output logic                  stall,
    output logic [NUM_SRC-1:0]    cmp_sel,
    output logic [ASEL_W-1:0]     asel,
    output logic                  st_ex,
    output logic                  st_me
);
    logic              load_use;
    logic              rt_alu_wait;
    logic [NUM_SRC-1:0] br_wait;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            br_wait[i] = branch && (hit_ex[i] || (hit_me[i] && me_ld));
            cmp_sel[i] = id_occ && branch && !hit_ex[i] && hit_me[i] && !me_ld;
        end
        load_use    = use_a && hit_ex[0] && ex_ld;
        rt_alu_wait = use_b && (hit_ex[1] || hit_me[1]);
        stall       = id_occ && (load_use || rt_alu_wait || (|br_wait));

        asel = ASEL_REG;
        if (use_a) begin
            if (hit_ex[0])      asel = ASEL_MEM;
            else if (hit_me[0]) asel = ASEL_WB;
        end
        st_me = store && hit_ex[1];
        st_ex = store && !hit_ex[1] && hit_me[1];
    end
endmodule

// File: rtl/bp_pipe_ctrl.sv
module bp_pipe_ctrl
    import bp_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int EXC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_occ,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_wr,
    input  logic             id_load,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic             id_branch,
    input  logic             id_store,
    input  logic [EXC_W-1:0] id_exc,
    input  logic [EXC_W-1:0] ex_exc_new,
    input  logic [EXC_W-1:0] me_exc_new,
    output logic             stall,
    output logic             id_cmp_a_sel,
    output logic             id_cmp_b_sel,
    output logic [1:0]       ex_alu_a_sel,
    output logic             ex_st_sel,
    output logic             me_st_sel,
    output logic             ex_occ,
    output logic             me_occ,
    output logic             wb_occ,
    output logic [EXC_W-1:0] wb_exc
);
    typedef struct packed {
        logic              occ;
        logic              wr;
        logic              ld;
        logic [REG_W-1:0]  dst;
        logic [EXC_W-1:0]  exc;
        logic [ASEL_W-1:0] asel;
        logic              st_ex;
        logic              st_me;
    } ex_rec_t;

    typedef struct packed {
        logic             occ;
        logic             wr;
        logic             ld;
        logic [REG_W-1:0] dst;
        logic [EXC_W-1:0] exc;
        logic             st_me;
    } me_rec_t;

    typedef struct packed {
        logic             occ;
        logic [EXC_W-1:0] exc;
    } wb_rec_t;

    typedef struct packed {
        ex_rec_t ex;
        me_rec_t me;
        wb_rec_t wb;
    } state_t;

    state_t state_d, state_q;

    logic [REG_W-1:0]  src [NUM_SRC];
    logic [NUM_SRC-1:0] hit_ex, hit_me;
    logic              raw_stall;
    logic [NUM_SRC-1:0] cmp_sel;
    logic [ASEL_W-1:0] asel_d;
    logic              st_ex_d, st_me_d;
    logic [EXC_W-1:0]  me_exc_w;

    assign src[0] = id_rs;
    assign src[1] = id_rt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        bp_src_match #(.REG_W(REG_W)) u_match (
            .src      (src[g]),
            .ex_hit_en(state_q.ex.occ && state_q.ex.wr),
            .ex_dst   (state_q.ex.dst),
            .me_hit_en(state_q.me.occ && state_q.me.wr),
            .me_dst   (state_q.me.dst),
            .hit_ex   (hit_ex[g]),
            .hit_me   (hit_me[g])
        );
    end

    bp_hazard_decide u_decide (
        .id_occ (id_occ),
        .use_a  (id_use_a),
        .use_b  (id_use_b),
        .branch (id_branch),
        .store  (id_store),
        .hit_ex (hit_ex),
        .hit_me (hit_me),
        .ex_ld  (state_q.ex.ld),
        .me_ld  (state_q.me.ld),
        .stall  (raw_stall),
        .cmp_sel(cmp_sel),
        .asel   (asel_d),
        .st_ex  (st_ex_d),
        .st_me  (st_me_d)
    );

    always_comb begin
        state_d = '0;

        if (id_occ && !raw_stall) begin
            state_d.ex.occ   = 1'b1;
            state_d.ex.wr    = id_wr;
            state_d.ex.ld    = id_load;
            state_d.ex.dst   = id_dst;
            state_d.ex.exc   = id_exc;
            state_d.ex.asel  = asel_d;
            state_d.ex.st_ex = st_ex_d;
            state_d.ex.st_me = st_me_d;
        end

        if (state_q.ex.occ) begin
            state_d.me.occ   = 1'b1;
            state_d.me.wr    = state_q.ex.wr;
            state_d.me.ld    = state_q.ex.ld;
            state_d.me.dst   = state_q.ex.dst;
            state_d.me.st_me = state_q.ex.st_me;
            state_d.me.exc   = (state_q.ex.exc != '0) ? state_q.ex.exc : ex_exc_new;
        end

        if (state_q.me.occ) begin
            state_d.wb.occ = 1'b1;
            state_d.wb.exc = (state_q.me.exc != '0) ? state_q.me.exc : me_exc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stall        = raw_stall;
    assign id_cmp_a_sel = cmp_sel[0];
    assign id_cmp_b_sel = cmp_sel[1];
    assign ex_alu_a_sel = state_q.ex.asel;
    assign ex_st_sel    = state_q.ex.st_ex;
    assign me_st_sel    = state_q.me.st_me;
    assign ex_occ       = state_q.ex.occ;
    assign me_occ       = state_q.me.occ;
    assign wb_occ       = state_q.wb.occ;
    assign wb_exc       = state_q.wb.exc;
    assign me_exc_w     = state_q.me.exc;
endmodule

// File: rtl/bp_ctrl_chk.sv
module bp_ctrl_chk #(
    parameter int REG_W = 5,
    parameter int EXC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_occ,
    input logic [REG_W-1:0] id_rs,
    input logic [REG_W-1:0] id_rt,
    input logic             stall,
    input logic             id_cmp_a_sel,
    input logic             id_cmp_b_sel,
    input logic [1:0]       ex_alu_a_sel,
    input logic             me_st_sel,
    input logic             ex_occ,
    input logic             me_occ,
    input logic             wb_occ,
    input logic [EXC_W-1:0] wb_exc,
    input logic [EXC_W-1:0] me_exc_w
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!ex_occ && !me_occ && !wb_occ && wb_exc == '0)); // R1

    AST_ALU_MEM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_alu_a_sel == 2'd1) |-> me_occ); // R2

    AST_RZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_occ && id_rs == '0 && id_rt == '0) |-> !stall); // R3

    AST_CMP_MEM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cmp_a_sel || id_cmp_b_sel) |-> me_occ); // R6

    AST_STORE_WB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        me_st_sel |-> wb_occ); // R7

    AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex_occ && ex_alu_a_sel == 2'd0)); // R8

    AST_OCC_EX_TO_ME: assert property (@(posedge clk) disable iff (!rst_n)
        ex_occ |=> me_occ); // R9

    AST_OCC_ME_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        me_occ |=> wb_occ); // R9

    AST_EXC_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (me_occ && me_exc_w != '0) |=> (wb_exc == $past(me_exc_w))); // R10

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !id_occ |-> (!stall && !id_cmp_a_sel && !id_cmp_b_sel)); // R11
endmodule

bind bp_pipe_ctrl bp_ctrl_chk #(.REG_W(REG_W), .EXC_W(EXC_W)) u_chk (.*);

// File: tb/tb_bp_pipe_ctrl.sv
module tb_bp_pipe_ctrl;
    localparam int RW = 3;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_occ = 0, id_wr = 0, id_load = 0, id_use_a = 0, id_use_b = 0;
    logic          id_branch = 0, id_store = 0;
    logic [RW-1:0] id_rs = 0, id_rt = 0, id_dst = 0;
    logic [EW-1:0] id_exc = 0, ex_exc_new = 0, me_exc_new = 0;
    logic          stall, id_cmp_a_sel, id_cmp_b_sel, ex_st_sel, me_st_sel;
    logic          ex_occ, me_occ, wb_occ;
    logic [1:0]    ex_alu_a_sel;
    logic [EW-1:0] wb_exc;

    int checks = 0, errors = 0;
    bit done = 0;
    bit last_stall, last_ca, last_cb;

    // bench model of the stage records
    bit m_ex_occ, m_ex_wr, m_ex_ld, m_ex_stex, m_ex_stme;
    bit [RW-1:0] m_ex_dst; bit [EW-1:0] m_ex_exc; bit [1:0] m_ex_asel;
    bit m_me_occ, m_me_wr, m_me_ld, m_me_stme;
    bit [RW-1:0] m_me_dst; bit [EW-1:0] m_me_exc;
    bit m_wb_occ; bit [EW-1:0] m_wb_exc;

    bp_pipe_ctrl #(.REG_W(RW), .EXC_W(EW)) dut (.*);

    always #5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit hitr(bit [RW-1:0] s, bit occ, bit wr, bit [RW-1:0] d);
        return (s != 0) && occ && wr && (d == s);
    endfunction

    function automatic void expect_id(output bit st, output bit ca, output bit cb,
                                      output bit [1:0] as, output bit sx, output bit sm);
        bit hx0, hm0, hx1, hm1;
        hx0 = hitr(id_rs, m_ex_occ, m_ex_wr, m_ex_dst);
        hm0 = hitr(id_rs, m_me_occ, m_me_wr, m_me_dst);
        hx1 = hitr(id_rt, m_ex_occ, m_ex_wr, m_ex_dst);
        hm1 = hitr(id_rt, m_me_occ, m_me_wr, m_me_dst);
        st = id_occ && ((id_use_a && hx0 && m_ex_ld) ||
                        (id_use_b && (hx1 || hm1)) ||
                        (id_branch && (hx0 || (hm0 && m_me_ld) || hx1 || (hm1 && m_me_ld))));
        ca = id_occ && id_branch && !hx0 && hm0 && !m_me_ld;
        cb = id_occ && id_branch && !hx1 && hm1 && !m_me_ld;
        as = !id_use_a ? 2'd0 : hx0 ? 2'd1 : hm0 ? 2'd2 : 2'd0;
        sx = id_store && !hx1 && hm1;
        sm = id_store && hx1;
    endfunction

    task automatic model_clear();
        m_ex_occ = 0; m_ex_wr = 0; m_ex_ld = 0; m_ex_stex = 0; m_ex_stme = 0;
        m_ex_dst = 0; m_ex_exc = 0; m_ex_asel = 0;
        m_me_occ = 0; m_me_wr = 0; m_me_ld = 0; m_me_stme = 0; m_me_dst = 0; m_me_exc = 0;
        m_wb_occ = 0; m_wb_exc = 0;
    endtask

    // one clock: comb checks before the edge, registered checks after it
    task automatic run_cycle();
        bit st, ca, cb, sx, sm; bit [1:0] as;
        #1;
        expect_id(st, ca, cb, as, sx, sm);
        chk("R4", "stall", stall, st);
        chk("R6", "cmp_a", id_cmp_a_sel, ca);
        chk("R6", "cmp_b", id_cmp_b_sel, cb);
        last_stall = stall; last_ca = id_cmp_a_sel; last_cb = id_cmp_b_sel;
        @(posedge clk);
        m_wb_occ = m_me_occ;
        m_wb_exc = m_me_occ ? ((m_me_exc != 0) ? m_me_exc : me_exc_new) : 0;
        m_me_occ = m_ex_occ; m_me_wr = m_ex_occ && m_ex_wr; m_me_ld = m_ex_occ && m_ex_ld;
        m_me_dst = m_ex_occ ? m_ex_dst : 0; m_me_stme = m_ex_occ && m_ex_stme;
        m_me_exc = m_ex_occ ? ((m_ex_exc != 0) ? m_ex_exc : ex_exc_new) : 0;
        if (id_occ && !st) begin
            m_ex_occ = 1; m_ex_wr = id_wr; m_ex_ld = id_load; m_ex_dst = id_dst;
            m_ex_exc = id_exc; m_ex_asel = as; m_ex_stex = sx; m_ex_stme = sm;
        end else begin
            m_ex_occ = 0; m_ex_wr = 0; m_ex_ld = 0; m_ex_dst = 0; m_ex_exc = 0;
            m_ex_asel = 0; m_ex_stex = 0; m_ex_stme = 0;
        end
        @(negedge clk);
        chk("R9", "ex_occ", ex_occ, m_ex_occ);
        chk("R9", "me_occ", me_occ, m_me_occ);
        chk("R9", "wb_occ", wb_occ, m_wb_occ);
        chk("R2", "ex_alu_a_sel", ex_alu_a_sel, m_ex_asel);
        chk("R7", "ex_st_sel", ex_st_sel, m_ex_stex);
        chk("R7", "me_st_sel", me_st_sel, m_me_stme);
        chk("R10", "wb_exc", wb_exc, m_wb_exc);
    endtask

    // kind: 0 idle, 1 alu rr, 2 alu imm, 3 load, 4 store, 5 branch
    task automatic set_id(int kind, int rs, int rt, int dst);
        id_occ = (kind != 0);
        id_rs = RW'(rs); id_rt = RW'(rt); id_dst = RW'(dst);
        id_use_a = (kind == 1 || kind == 2 || kind == 3 || kind == 4);
        id_use_b = (kind == 1);
        id_wr = (kind == 1 || kind == 2 || kind == 3);
        id_load = (kind == 3);
        id_store = (kind == 4);
        id_branch = (kind == 5);
    endtask

    task automatic flush();
        set_id(0, 0, 0, 0);
        id_exc = 0; ex_exc_new = 0; me_exc_new = 0;
        repeat (3) run_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "ex_occ", ex_occ, 0);
        chk("R1", "me_occ", me_occ, 0);
        chk("R1", "wb_occ", wb_occ, 0);
        chk("R1", "wb_exc", wb_exc, 0);
        chk("R1", "ex_alu_a_sel", ex_alu_a_sel, 0);
        rst_n = 1'b1;

        // R4 / R8: load-use on upper operand
        set_id(3, 0, 0, 1); run_cycle();
        set_id(2, 1, 0, 2); run_cycle();
        chk("R4", "load-use stall", last_stall, 1);
        chk("R8", "bubble ex_occ", ex_occ, 0);
        chk("R8", "bubble asel", ex_alu_a_sel, 0);
        run_cycle();
        chk("R4", "stall released", last_stall, 0);
        chk("R4", "asel after load", ex_alu_a_sel, 2);
        flush();

        // R6: branch on ALU result in EX
        set_id(2, 0, 0, 1); run_cycle();
        set_id(5, 1, 0, 0); run_cycle();
        chk("R6", "branch stall", last_stall, 1);
        run_cycle();
        chk("R6", "branch stall released", last_stall, 0);
        chk("R6", "cmp_a mem", last_ca, 1);
        chk("R6", "cmp_b reg", last_cb, 0);
        flush();

        // R2: youngest producer wins
        set_id(2, 0, 0, 1); run_cycle();
        set_id(2, 0, 0, 1); run_cycle();
        set_id(2, 1, 0, 3); run_cycle();
        chk("R2", "youngest asel", ex_alu_a_sel, 1);
        flush();

        // R3: register 0 never matches
        set_id(3, 0, 0, 0); run_cycle();
        set_id(1, 0, 0, 2); run_cycle();
        chk("R3", "r0 no stall", last_stall, 0);
        chk("R3", "r0 asel", ex_alu_a_sel, 0);
        flush();

        // R7: store data after load, and after ALU in MEM
        set_id(3, 0, 0, 5); run_cycle();
        set_id(4, 0, 5, 0); run_cycle();
        chk("R7", "store no stall", last_stall, 0);
        chk("R7", "ex_st_sel", ex_st_sel, 0);
        set_id(0, 0, 0, 0); run_cycle();
        chk("R7", "me_st_sel", me_st_sel, 1);
        flush();
        set_id(2, 0, 0, 6); run_cycle();
        set_id(0, 0, 0, 0); run_cycle();
        set_id(4, 0, 6, 0); run_cycle();
        chk("R7", "ex_st_sel mem producer", ex_st_sel, 1);
        flush();

        // R5: lower operand waits for writeback
        set_id(2, 0, 0, 4); run_cycle();
        set_id(1, 0, 4, 2); run_cycle();
        chk("R5", "rt stall 1", last_stall, 1);
        run_cycle();
        chk("R5", "rt stall 2", last_stall, 1);
        run_cycle();
        chk("R5", "rt released", last_stall, 0);
        flush();

        // R10: exception priority
        set_id(2, 0, 0, 1); id_exc = 3; ex_exc_new = 5; me_exc_new = 7; run_cycle();
        set_id(0, 0, 0, 0); id_exc = 0; run_cycle(); run_cycle();
        chk("R10", "older code kept", wb_exc, 3);
        set_id(2, 0, 0, 1); id_exc = 0; ex_exc_new = 6; run_cycle();
        set_id(0, 0, 0, 0); run_cycle(); run_cycle();
        chk("R10", "new code taken", wb_exc, 6);
        flush();

        // R11: idle decode never stalls
        set_id(3, 0, 0, 1); run_cycle();
        set_id(2, 1, 1, 2); id_occ = 0; run_cycle();
        chk("R11", "idle no stall", last_stall, 0);
        flush();

        // random mix
        for (int n = 0; n < 3000; n++) begin
            if (!last_stall) begin
                set_id($urandom_range(0, 5), $urandom_range(0, 7), $urandom_range(0, 7),
                       $urandom_range(0, 7));
                id_exc = ($urandom_range(0, 7) == 0) ? EW'($urandom_range(1, 7)) : '0;
            end
            ex_exc_new = ($urandom_range(0, 5) == 0) ? EW'($urandom_range(1, 7)) : '0;
            me_exc_new = ($urandom_range(0, 5) == 0) ? EW'($urandom_range(1, 7)) : '0;
            run_cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule